// File: doc/BRIEF.md
# Loop Fetch Buffer

This block sits inside an instruction fetch stage and keeps a copy of the bytes most recently fetched in sequence. Every byte that the fetch side brings in from memory is written into the buffer with its address. The buffer is filled only as a side effect of normal fetch and never on demand. A loop body that fits in the buffer therefore needs memory only on its first pass.

When a branch redirects fetch, the target address is presented as a lookup before any memory request goes out. The low address bits select one byte slot. The high address bits are compared with the tag stored in that slot. One cycle later the block reports hit or miss, and on a hit it also returns the stored byte for the decoder. A new write simply overwrites the slot its address maps to. A flush input invalidates the whole buffer.

Top module: `loop_fetch_buffer`

## Requirements
- R1: After synchronous reset, every slot is invalid. All three response outputs are 0, and any lookup misses until a byte is written.
- R2: A lookup presented in cycle N produces `rsp_valid_o`=1 in cycle N+1. If a byte was written at exactly that address in an earlier cycle, the response has `rsp_hit_o`=1 and `rsp_data_o` equal to that byte.
- R3: The slot is selected by address bits [IDX_W-1:0], which are bits [7:0] by default, giving 256 slots. A lookup whose slot holds bytes from a different high part of the address (bits [ADDR_W-1:IDX_W]) misses.
- R4: A write to an address that maps to an occupied slot replaces that slot's tag and byte. Afterwards the old address misses and the new address hits.
- R5: While `flush_i`=1, all slots become invalid, and a write in the same cycle is discarded. A lookup in a flush cycle misses, and every later lookup misses until a new write.
- R6: When a lookup and a write in the same non-flush cycle map to the same slot, the response reflects the new write. It hits with the written byte if the full addresses match, and misses otherwise.
- R7: In a cycle after one with `lk_req_i`=0, `rsp_valid_o` and `rsp_hit_o` are both 0.
- R8: After 256 consecutive sequential byte writes, all 256 addresses hit with their bytes. The next sequential write wraps to slot 0 and evicts the oldest byte.
- R9: A response that misses drives `rsp_data_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate every slot |
| wr_en_i | input | 1 | A fetched byte is written this cycle |
| wr_addr_i | input | ADDR_W | Address of the fetched byte |
| wr_data_i | input | DATA_W | Fetched byte |
| lk_req_i | input | 1 | Branch target lookup request |
| lk_addr_i | input | ADDR_W | Branch target address |
| rsp_valid_o | output | 1 | A lookup response is present this cycle |
| rsp_hit_o | output | 1 | The target was found in the buffer |
| rsp_data_o | output | DATA_W | Stored byte on a hit, 0 on a miss |

## Verification
A wrong valid bit or tag shows up as a false hit or a false miss in the cycle after a lookup to that slot. A corrupted byte appears on `rsp_data_o` in that same response cycle. Forwarding errors are visible only when a write and a lookup share a slot in one cycle, so the bench drives that case with both matching and non-matching tags. A stale slot after a flush or a wrap-around eviction shows up as a hit on the first lookup of the evicted address.

// File: rtl/loop_buf_pkg.sv
package loop_buf_pkg;

    localparam int LB_ADDR_W = 16;
    localparam int LB_IDX_W  = 8;
    localparam int LB_DATA_W = 8;

    // Where the lookup answer comes from in the request cycle
    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_FLUSH = 2'd1,
        SRC_FWD   = 2'd2,
        SRC_ARRAY = 2'd3
    } lk_src_e;

    function automatic lk_src_e pick_source(input logic req, input logic flush,
                                            input logic same_slot_write);
        if (!req)                 return SRC_IDLE;
        else if (flush)           return SRC_FLUSH;
        else if (same_slot_write) return SRC_FWD;
        else                      return SRC_ARRAY;
    endfunction

endpackage

// File: rtl/lb_valid_bits.sv
module lb_valid_bits #(
    parameter int IDX_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid
);

    logic [DEPTH-1:0] vld_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                vld_q[i] <= 1'b0;
            end else if (set_en && set_idx == SLOT) begin
                vld_q[i] <= 1'b1;
            end
        end
    end

    assign rd_valid = vld_q[rd_idx];

    // R5: a flush leaves no slot valid in the next cycle
    p_flush_clears_r5: assert property (@(posedge clk) disable iff (rst)
        flush |=> ($countones(vld_q) == 0));

    // R4/R8: a write makes exactly its slot valid
    p_set_marks_r8: assert property (@(posedge clk) disable iff (rst)
        (set_en && !flush) |=> vld_q[$past(set_idx)]);

endmodule

// File: rtl/lb_slot_array.sv
module lb_slot_array #(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t mem_q [DEPTH];
    slot_t rd_slot;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= '{tag: wr_tag, data: wr_data};
        end
    end

    assign rd_slot = mem_q[rd_idx];
    assign rd_tag  = rd_slot.tag;
    assign rd_data = rd_slot.data;

endmodule

// File: rtl/lb_probe.sv
module lb_probe
    import loop_buf_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lk_req,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              arr_valid,
    input  logic [TAG_W-1:0]  arr_tag,
    input  logic [DATA_W-1:0] arr_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [DATA_W-1:0] data;
    } rsp_t;

    lk_src_e src;
    rsp_t    rsp_n, rsp_q;

    always_comb begin
        src   = pick_source(lk_req, flush, wr_en && (wr_idx == lk_idx));
        rsp_n = '0;
        rsp_n.valid = lk_req;
        unique case (src)
            SRC_FWD: begin
                rsp_n.hit  = (wr_tag == lk_tag);
                rsp_n.data = rsp_n.hit ? wr_data : '0;
            end
            SRC_ARRAY: begin
                rsp_n.hit  = arr_valid && (arr_tag == lk_tag);
                rsp_n.data = rsp_n.hit ? arr_data : '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_n;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_data  = rsp_q.data;

    // R2: a response follows every request by exactly one cycle
    p_rsp_timing_r2: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid);

    // R7: no request, no response
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> (!rsp_valid && !rsp_hit));

    // R5: lookups during a flush miss
    p_flush_miss_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_req && flush) |=> !rsp_hit);

    // R6: same-cycle write to the same address is forwarded
    p_forward_r6: assert property (@(posedge clk) disable iff (rst)
        (lk_req && wr_en && !flush && wr_idx == lk_idx && wr_tag == lk_tag)
        |=> (rsp_hit && rsp_data == $past(wr_data)));

    // R9: misses carry zero data
    p_miss_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_data == '0));

endmodule

// File: rtl/loop_fetch_buffer.sv
module loop_fetch_buffer
    import loop_buf_pkg::*;
#(
    parameter int ADDR_W = LB_ADDR_W,
    parameter int IDX_W  = LB_IDX_W,
    parameter int DATA_W = LB_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              lk_req_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [DATA_W-1:0] rsp_data_o
);

    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  wr_idx, lk_idx;
    logic [TAG_W-1:0]  wr_tag, lk_tag, arr_tag;
    logic [DATA_W-1:0] arr_data;
    logic              arr_valid;
    logic              wr_commit;

    assign wr_idx    = wr_addr_i[IDX_W-1:0];
    assign wr_tag    = wr_addr_i[ADDR_W-1:IDX_W];
    assign lk_idx    = lk_addr_i[IDX_W-1:0];
    assign lk_tag    = lk_addr_i[ADDR_W-1:IDX_W];
    assign wr_commit = wr_en_i && !flush_i;

    lb_valid_bits #(.IDX_W(IDX_W)) u_valid (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush_i),
        .set_en   (wr_commit),
        .set_idx  (wr_idx),
        .rd_idx   (lk_idx),
        .rd_valid (arr_valid)
    );

    lb_slot_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .wr_en   (wr_commit),
        .wr_idx  (wr_idx),
        .wr_tag  (wr_tag),
        .wr_data (wr_data_i),
        .rd_idx  (lk_idx),
        .rd_tag  (arr_tag),
        .rd_data (arr_data)
    );

    lb_probe #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_probe (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_i),
        .wr_en     (wr_en_i),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_data   (wr_data_i),
        .lk_req    (lk_req_i),
        .lk_idx    (lk_idx),
        .lk_tag    (lk_tag),
        .arr_valid (arr_valid),
        .arr_tag   (arr_tag),
        .arr_data  (arr_data),
        .rsp_valid (rsp_valid_o),
        .rsp_hit   (rsp_hit_o),
        .rsp_data  (rsp_data_o)
    );

    // R4: a write then a lookup of the same address next cycle hits with that byte
    p_write_then_hit_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !flush_i) |=>
        ((lk_req_i && !flush_i && lk_addr_i == $past(wr_addr_i)
          && !(wr_en_i && wr_idx == lk_idx)) |=> (rsp_hit_o && rsp_data_o == $past(wr_data_i, 2))));

endmodule

// File: tb/loop_fetch_buffer_test.sv
module loop_fetch_buffer_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int IW = 8;
    localparam int DW = 8;
    localparam int NSLOT = 1 << IW;

    logic          clk = 1'b0;
    logic          rst;
    logic          flush_i, wr_en_i, lk_req_i;
    logic [AW-1:0] wr_addr_i, lk_addr_i;
    logic [DW-1:0] wr_data_i;
    logic          rsp_valid_o, rsp_hit_o;
    logic [DW-1:0] rsp_data_o;

    loop_fetch_buffer uut (
        .clk(clk), .rst(rst), .flush_i(flush_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .lk_req_i(lk_req_i), .lk_addr_i(lk_addr_i),
        .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_data_o(rsp_data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic          v;
        logic          hit;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // Requirement-level model of the buffer contents
    logic          m_v [NSLOT];
    logic [AW-1:0] m_a [NSLOT];
    logic [DW-1:0] m_d [NSLOT];

    task automatic model_clear();
        for (int i = 0; i < NSLOT; i++) begin
            m_v[i] = 1'b0; m_a[i] = '0; m_d[i] = '0;
        end
    endtask

    task automatic check(string req, logic [DW+1:0] act, logic [DW+1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: got valid/hit/data=%b expected %b", req, act, expv);
        end
    endtask

    // Driver: one clock cycle of stimulus, expected response pushed to the scoreboard
    task automatic cyc(string req, logic fl, logic we, logic [AW-1:0] wa, logic [DW-1:0] wd,
                       logic lr, logic [AW-1:0] la);
        exp_t e;
        int li, wi;
        @(negedge clk);
        flush_i = fl; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
        lk_req_i = lr; lk_addr_i = la;
        li = int'(la[IW-1:0]);
        wi = int'(wa[IW-1:0]);
        e.v = lr; e.hit = 1'b0; e.data = '0; e.req = req;
        if (lr && !fl) begin
            if (we && wi == li) begin
                e.hit  = (wa == la);
                e.data = e.hit ? wd : '0;
            end else begin
                e.hit  = m_v[li] && (m_a[li] == la);
                e.data = e.hit ? m_d[li] : '0;
            end
        end
        exp_q.push_back(e);
        if (fl) model_clear();
        else if (we) begin m_v[wi] = 1'b1; m_a[wi] = wa; m_d[wi] = wd; end
    endtask

    task automatic wr(string req, logic [AW-1:0] a, logic [DW-1:0] d);
        cyc(req, 1'b0, 1'b1, a, d, 1'b0, '0);
    endtask

    task automatic lk(string req, logic [AW-1:0] a);
        cyc(req, 1'b0, 1'b0, '0, '0, 1'b1, a);
    endtask

    // Monitor: compares each cycle's response just after the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, {rsp_valid_o, rsp_hit_o, rsp_data_o}, {e.v, e.hit, e.data});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        rst = 1'b1; flush_i = 0; wr_en_i = 0; lk_req_i = 0;
        wr_addr_i = '0; lk_addr_i = '0; wr_data_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        check("R1", {rsp_valid_o, rsp_hit_o, rsp_data_o}, '0);
        lk("R1", 16'h0000);
        lk("R1", 16'h12AB);

        // R2: sequential fill then hits
        for (int i = 0; i < 4; i++) wr("R2", 16'h1000 + AW'(i), 8'hA0 + DW'(i));
        for (int i = 0; i < 4; i++) lk("R2", 16'h1000 + AW'(i));

        // R3 / R9: same slot, different high bits
        lk("R3", 16'h2000);
        lk("R9", 16'h1100);

        // R7: idle cycles
        cyc("R7", 0, 0, '0, '0, 0, 16'h1000);
        cyc("R7", 0, 1, 16'h1010, 8'h77, 0, 16'h1010);

        // R6: write and lookup in the same cycle
        cyc("R6", 0, 1, 16'h3005, 8'h5C, 1, 16'h3005);
        cyc("R6", 0, 1, 16'h3006, 8'h6D, 1, 16'h4006);
        cyc("R6", 0, 1, 16'h3007, 8'h11, 1, 16'h3008);
        lk("R6", 16'h3006);

        // R4: overwrite a slot
        wr("R4", 16'h5000, 8'hE1);
        lk("R4", 16'h1000);
        lk("R4", 16'h5000);

        // R8: full-capacity sequential fill and wrap
        for (int i = 0; i < NSLOT; i++) wr("R8", 16'h0700 + AW'(i), DW'(i) ^ 8'h5A);
        for (int i = 0; i < NSLOT; i++) lk("R8", 16'h0700 + AW'(i));
        wr("R8", 16'h0800, 8'hC3);
        lk("R8", 16'h0700);
        lk("R8", 16'h0800);
        lk("R8", 16'h0701);

        // R5: flush discards a same-cycle write and clears every slot
        cyc("R5", 1, 1, 16'h0900, 8'h99, 1, 16'h0702);
        lk("R5", 16'h0701);
        lk("R5", 16'h0900);
        lk("R5", 16'h0800);
        wr("R5", 16'h0A03, 8'h3C);
        lk("R5", 16'h0A03);

        cyc("R7", 0, 0, '0, '0, 0, '0);
        repeat (3) @(posedge clk);
        #2;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule